// File: doc/BRIEF.md
# Dual-Channel Converter Ramp Pattern Checker

This block watches a stream of paired in-phase (I) and quadrature (Q) converter test samples and decides, for each channel on its own, whether the data is a clean incrementing ramp. It is used during converter bring-up and capture-delay calibration. The converter is placed in a ramp test mode. Software then pulses the enable low and back high and waits for a while. It then reads a three-way verdict per channel: not locked, locked with bit errors, or good.

Each 32-bit sample word carries I in the upper half and Q in the lower half. Each half holds a 14-bit converter value in its upper 14 bits, with two pad bits below. The I half reaches the block with its data bits inverted, so the checker flips them back before comparing. A channel only starts checking once it sees a zero value. From then on it expects each value to be one more than the last, modulo 2^14. Any deviation raises a sticky error flag and adds to a shared error counter, which saturates at its maximum.

Top module: `adc_ramp_checker`

## Requirements
- R1: Channel I is `~sample_word[31:18]` (14 bits); channel Q is `sample_word[15:2]`; so a word of 0xFFFC0000 carries zero on both channels.
- R2: A channel locks on the first valid sample whose value is zero. Nonzero samples before lock raise no error and do not count.
- R3: After lock, the expected value of each later valid sample is one more than the previous expected value. 0x3FFF is followed by 0 without error.
- R4: A locked channel whose valid sample differs from the expected value sets its error flag. The flag stays set until the next enable restart, and later correct samples do not clear it.
- R5: The two pad bits of each half (bits 17:16 and 1:0) have no effect on any result.
- R6: `err_count` adds one for each channel that mismatches on a valid sample, so a single sample can add two. It saturates at 2^CNT_W-1.
- R7: While `enable` is low, every status output reads zero and all lock, error and count state is cleared. When enable is raised again, acquisition restarts from the unlocked state.
- R8: `i_status`/`q_status` encode 2'b00 = not locked, 2'b01 = locked with bit errors, 2'b10 = locked and good.
- R9: The I and Q channels lock and flag errors independently of each other.
- R10: A sample with `sample_valid` low changes no state.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Checker run level; low clears, rising restarts |
| sample_valid | input | 1 | Qualifies sample_word this cycle |
| sample_word | input | 32 | I half in 31:16 (inverted), Q half in 15:0 |
| i_locked | output | 1 | I channel has seen its zero and is tracking |
| i_error | output | 1 | I channel mismatch seen since lock |
| q_locked | output | 1 | Q channel has seen its zero and is tracking |
| q_error | output | 1 | Q channel mismatch seen since lock |
| i_status | output | 2 | I verdict code |
| q_status | output | 2 | Q verdict code |
| err_count | output | CNT_W | Saturating mismatch count, both channels |

## Verification
The assertions assume that `enable` is held low throughout reset, and that `sample_valid` and `sample_word` are stable at each rising edge. Stimulus keeps to this by changing every input only on the falling clock edge and keeping enable low until reset has been released. The bench builds each word from two 14-bit channel values. It inverts the I value before driving it, so the expected results follow directly from the ramp values and do not depend on how the design decodes the word.

// File: rtl/adc_ramp_pkg.sv
package adc_ramp_pkg;

  // Per-channel verdict code
  typedef enum logic [1:0] {
    ST_NOLOCK = 2'b00,
    ST_BITERR = 2'b01,
    ST_GOOD   = 2'b10
  } lane_status_e;

endpackage

// File: rtl/ramp_lane.sv
module ramp_lane #(
  parameter int CONV_W = 14,
  parameter int PAD_W  = 2,
  parameter bit INVERT = 1'b0,
  localparam int HALF_W = CONV_W + PAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              valid,
  input  logic [HALF_W-1:0] half,
  output logic              locked,
  output logic              errored,
  output logic              miss
);

  localparam logic [CONV_W-1:0] FLIP = INVERT ? {CONV_W{1'b1}} : '0;
  localparam logic [CONV_W-1:0] ONE  = CONV_W'(1);

  logic [CONV_W-1:0] value;
  logic [CONV_W-1:0] expect_q, expect_d;
  logic              lock_q, lock_d;
  logic              err_q, err_d;
  logic              upd_en;

  // pad bits dropped, fixed inversion undone
  assign value = half[HALF_W-1:PAD_W] ^ FLIP;

  assign miss   = enable && valid && lock_q && (value != expect_q);
  assign upd_en = !enable || valid;

  always_comb begin
    lock_d   = lock_q;
    err_d    = err_q;
    expect_d = expect_q;
    if (!enable) begin
      lock_d   = 1'b0;
      err_d    = 1'b0;
      expect_d = '0;
    end else if (valid) begin
      if (!lock_q) begin
        if (value == '0) begin
          lock_d   = 1'b1;
          expect_d = ONE;
        end
      end else begin
        expect_d = expect_q + ONE;
        if (value != expect_q) err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      err_q    <= 1'b0;
      expect_q <= '0;
    end else if (upd_en) begin
      lock_q   <= lock_d;
      err_q    <= err_d;
      expect_q <= expect_d;
    end
  end

  assign locked  = lock_q;
  assign errored = err_q;

  assert_err_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> lock_q);

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && enable) |=> err_q);

  assert_lock_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(enable && valid && (value == '0)));

  assert_clear_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> (!lock_q && !err_q));

  assert_hold_no_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !valid) |=> $stable(lock_q) && $stable(err_q));

endmodule

// File: rtl/err_counter.sv
module err_counter #(
  parameter int CNT_W = 16,
  parameter int N_IN  = 2,
  localparam int SUM_W = CNT_W + $clog2(N_IN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [N_IN-1:0]  inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [SUM_W-1:0] MAXV = SUM_W'({CNT_W{1'b1}});

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wide;

  always_comb begin
    sum = '0;
    for (int k = 0; k < N_IN; k++) sum = sum + SUM_W'(inc[k]);
    wide = SUM_W'(cnt_q) + sum;
    if (clear)           cnt_d = '0;
    else if (wide > MAXV) cnt_d = {CNT_W{1'b1}};
    else                 cnt_d = wide[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (cnt_q >= $past(cnt_q)));

  assert_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/lane_status.sv
module lane_status
  import adc_ramp_pkg::*;
(
  input  logic       enable,
  input  logic       locked,
  input  logic       errored,
  output logic [1:0] status
);

  lane_status_e code;

  always_comb begin
    if (!enable || !locked) code = ST_NOLOCK;
    else if (errored)       code = ST_BITERR;
    else                    code = ST_GOOD;
  end

  assign status = code;

endmodule

// File: rtl/adc_ramp_checker.sv
module adc_ramp_checker #(
  parameter int CONV_W = 14,
  parameter int PAD_W  = 2,
  parameter int CNT_W  = 16,
  localparam int HALF_W = CONV_W + PAD_W,
  localparam int NUM_CH = 2,
  localparam int WORD_W = HALF_W * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sample_valid,
  input  logic [WORD_W-1:0] sample_word,
  output logic              i_locked,
  output logic              i_error,
  output logic              q_locked,
  output logic              q_error,
  output logic [1:0]        i_status,
  output logic [1:0]        q_status,
  output logic [CNT_W-1:0]  err_count
);

  logic [NUM_CH-1:0] lock_v, err_v, miss_v;
  logic [1:0]        stat_v [NUM_CH];

  // channel 0 is I (upper half, inverted), channel 1 is Q
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    ramp_lane #(
      .CONV_W (CONV_W),
      .PAD_W  (PAD_W),
      .INVERT (ch == 0)
    ) i_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .valid   (sample_valid),
      .half    (sample_word[HALF_W*(NUM_CH-ch)-1 -: HALF_W]),
      .locked  (lock_v[ch]),
      .errored (err_v[ch]),
      .miss    (miss_v[ch])
    );

    lane_status i_stat (
      .enable  (enable),
      .locked  (lock_v[ch]),
      .errored (err_v[ch]),
      .status  (stat_v[ch])
    );
  end

  err_counter #(
    .CNT_W (CNT_W),
    .N_IN  (NUM_CH)
  ) i_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!enable),
    .inc   (miss_v),
    .count (err_count)
  );

  assign i_locked = enable & lock_v[0];
  assign i_error  = enable & err_v[0];
  assign q_locked = enable & lock_v[1];
  assign q_error  = enable & err_v[1];
  assign i_status = stat_v[0];
  assign q_status = stat_v[1];

  assert_status_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(i_status) && $onehot0(q_status));

  assert_count_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !sample_valid) |=> $stable(err_count));

endmodule

// File: tb/test_adc_ramp_checker.sv
module test_adc_ramp_checker;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        sample_valid;
  logic [31:0] sample_word;
  logic        i_locked, i_error, q_locked, q_error;
  logic [1:0]  i_status, q_status;
  logic [CNT_W-1:0] err_count;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ramp_checker #(.CNT_W(CNT_W)) i_adc_ramp_checker (
    .clk (clk), .rst_n (rst_n), .enable (enable),
    .sample_valid (sample_valid), .sample_word (sample_word),
    .i_locked (i_locked), .i_error (i_error),
    .q_locked (q_locked), .q_error (q_error),
    .i_status (i_status), .q_status (q_status),
    .err_count (err_count)
  );

  // word from channel values: I inverted into 31:18, Q into 15:2
  function automatic logic [31:0] mkw(logic [13:0] iv, logic [13:0] qv);
    return {~iv, 2'b00, qv, 2'b00};
  endfunction

  // {I value, Q value, i_lk, i_er, q_lk, q_er, count}
  localparam int NV = 8;
  localparam logic [35:0] VEC [NV] = '{
    {14'd5, 14'd7, 4'b0000, 4'd0},   // R2 nonzero before lock ignored
    {14'd0, 14'd3, 4'b1000, 4'd0},   // R2 I locks, R9 Q stays out
    {14'd1, 14'd0, 4'b1010, 4'd0},   // R3 I tracks, Q locks
    {14'd2, 14'd1, 4'b1010, 4'd0},   // R3
    {14'd9, 14'd2, 4'b1110, 4'd1},   // R4 I mismatch
    {14'd4, 14'd3, 4'b1110, 4'd1},   // R4 sticky, expectation runs on
    {14'd5, 14'd7, 4'b1111, 4'd2},   // R9 Q mismatch alone
    {14'd7, 14'd5, 4'b1111, 4'd3}    // R6 I mismatch again
  };

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [31:0] w);
    @(negedge clk);
    sample_valid = v;
    sample_word  = w;
    @(posedge clk);
    #1;
  endtask

  task automatic restart();
    @(negedge clk);
    enable = 1'b0;
    sample_valid = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; sample_valid = 1'b0; sample_word = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset outputs", {i_locked, i_error, q_locked, q_error, i_status, q_status, err_count}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    enable = 1'b1;

    // R1 table walk (words built via the I inversion)
    for (int k = 0; k < NV; k++) begin
      step(1'b1, mkw(VEC[k][35:22], VEC[k][21:8]));
      chk($sformatf("R1 vec%0d flags", k), {i_locked, i_error, q_locked, q_error}, VEC[k][7:4]);
      chk($sformatf("R6 vec%0d count", k), err_count, VEC[k][3:0]);
    end
    chk("R8 I status biterr", i_status, 2'b01);

    // R10 invalid bad sample changes nothing
    step(1'b0, mkw(14'h123, 14'h321));
    chk("R10 count held", err_count, 3);

    // R7 enable low: outputs zero, restart clears
    @(negedge clk); enable = 1'b0; sample_valid = 1'b0;
    #1;
    chk("R7 outputs zero while off", {i_locked, i_error, q_locked, q_error, i_status, q_status}, 0);
    @(posedge clk); #1;
    @(negedge clk); enable = 1'b1;
    #1;
    chk("R7 restart unlocked", {i_locked, i_error, q_locked, q_error, err_count}, 0);
    chk("R8 status nolock", {i_status, q_status}, 0);

    // R3 full ramp with wrap, R5 pad bits toggled, R8 good
    for (int v = 0; v < 16384; v++)
      step(1'b1, mkw(14'(v), 14'(v)) | ((v % 2 == 1) ? 32'h0003_0003 : 32'h0));
    chk("R3 no error up to top", {i_error, q_error, err_count}, 0);
    step(1'b1, mkw(14'd0, 14'd0) | 32'h0001_0002);
    chk("R3 wrap no error", {i_error, q_error, err_count}, 0);
    step(1'b1, mkw(14'd1, 14'd1));
    chk("R5 pad bits ignored", {i_locked, i_error, q_locked, q_error}, 4'b1010);
    chk("R8 status good", {i_status, q_status}, 4'b1010);

    // R6 both channels mismatch: +2 per sample, saturate at 15
    for (int k = 0; k < 7; k++) step(1'b1, mkw(14'h2AAA, 14'h1555));
    chk("R6 count fourteen", err_count, 14);
    step(1'b1, mkw(14'h2AAA, 14'h1555));
    chk("R6 saturate", err_count, 15);
    step(1'b1, mkw(14'h2AAA, 14'h1555));
    chk("R6 stays saturated", err_count, 15);

    // R1 word 0xFFFC0000 is zero on both channels
    restart();
    step(1'b1, 32'hFFFC_0000);
    chk("R1 zero word locks both", {i_locked, q_locked}, 2'b11);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule